// File: doc/BRIEF.md
# SIMD Integer Multiply-Accumulate Unit

This block decodes one 32-bit vector instruction word and performs a lane-wise integer multiply on two 128-bit operands. Four operations belong to its encoding group: plain multiply, carry-less (polynomial) multiply, multiply-add into the old destination value, and multiply-subtract from it. Lanes are 8, 16 or 32 bits wide. A half-width form works on the low 64 bits only and returns zero in the upper 64 bits. The caller supplies the word and the three operand values that the word's register fields name: the two sources and the old destination. The block returns the result, a write-enable, an illegal-instruction flag and the destination index.

Both sides use a valid/ready stream. The input is taken on a clock edge where `in_valid` and `in_ready` are both high. The result appears one clock later with `out_valid` high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds every field unchanged and accepts no new input. The producer may hold `in_valid` high for as long as it likes. Words that fall outside the group, or use an illegal lane size, still produce a result beat: it has the illegal flag set, write-enable low and the data zero.

Top module: `simd_mac_unit`

## Requirements
- R1: The group is recognised only when bit 31 = 0, bits 28:24 = 01110, bit 21 = 1, and bits 15,14,13,12,10 = 1,0,0,1,1 (bit 11 free). For any other word the beat returns illegal = 1, write-enable = 0 and result = 0.
- R2: With bit 11 = 1 and bit 29 = 0, each lane returns the low lane-width bits of the product of the matching source lanes. Bits 23:22 select the lane width: 0 = 8, 1 = 16, 2 = 32.
- R3: With bit 11 = 0 and bit 29 = 0, each lane returns the old destination lane plus the product, modulo 2^width.
- R4: With bit 11 = 0 and bit 29 = 1, each lane returns the old destination lane minus the product, modulo 2^width.
- R5: With bit 11 = 1, bit 29 = 1 and size 0, each 8-bit lane returns the carry-less product over GF(2), truncated to 8 bits.
- R6: Carry-less multiply with size 1 or 2 is illegal: illegal = 1, write-enable = 0, result = 0.
- R7: Size 3 is illegal for all four operations, with the same outputs as R6.
- R8: Bit 30 = 0 computes the low 64 bits and forces result bits 127:64 to zero. Bit 30 = 1 computes all 128 bits.
- R9: `out_dst` carries bits 4:0 of the accepted word, and legal beats raise write-enable.
- R10: A beat accepted at a clock edge appears at the next edge. `in_ready` = not `out_valid` or `out_ready`. A stalled output holds all fields stable.
- R11: A synchronous active-high reset clears `out_valid`. After reset, `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat |
| in_insn | input | 32 | Instruction word |
| in_vn | input | 128 | First source operand |
| in_vm | input | 128 | Second source operand |
| in_vd | input | 128 | Old destination value |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 128 | Lane-wise result |
| out_wr_en | output | 1 | Result should be written back |
| out_illegal | output | 1 | Word was not a legal group member |
| out_dst | output | 5 | Destination register index |

## Verification
The bench targets lane carries that must not spill into the neighbouring lane. A design that multiplied the full vector, or took the wrong slice, would corrupt the high lanes of the all-ones patterns. Wrap-around in multiply-subtract is checked against a zero destination; a sign-extending or saturating design would return the wrong lanes. Carry-less multiply is compared with ordinary multiply on the same operands, and its wider sizes are driven to confirm they are rejected. The words that differ from a legal one in a single recognition bit must be flagged illegal with zero data. The half-width form must zero the upper half. The stall test holds `out_ready` low while a second word waits, and fails a design that overwrites or drops the held beat.

// File: rtl/simd_mac_pkg.sv
package simd_mac_pkg;
  localparam int INSN_W = 32;
  localparam int REG_IDX_W = 5;

  typedef enum logic [1:0] {
    OP_MUL  = 2'd0,
    OP_PMUL = 2'd1,
    OP_MLA  = 2'd2,
    OP_MLS  = 2'd3
  } mac_op_e;

  typedef struct packed {
    logic                 legal;
    mac_op_e              op;
    logic [1:0]           size;
    logic                 full;
    logic [REG_IDX_W-1:0] dst;
  } mac_dec_t;
endpackage

// File: rtl/simd_mac_decode.sv
module simd_mac_decode
  import simd_mac_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output mac_dec_t          dec
);
  logic in_group;
  logic no_acc;
  logic neg_bit;
  logic size_ok;
  logic unused_src_fields;

  // Group match: fixed bits, bit 11 is the operation selector
  assign in_group = !insn[31]
                 && (insn[28:24] == 5'b01110)
                 && insn[21]
                 && ((insn[15:10] & 6'b111101) == 6'b100101);

  assign no_acc  = insn[11];
  assign neg_bit = insn[29];

  always_comb begin
    if (no_acc) dec.op = neg_bit ? OP_PMUL : OP_MUL;
    else        dec.op = neg_bit ? OP_MLS  : OP_MLA;
  end

  // Carry-less form only exists for byte lanes; 64-bit lanes never exist
  always_comb begin
    size_ok = (insn[23:22] != 2'b11);
    if (dec.op == OP_PMUL && insn[23:22] != 2'b00) size_ok = 1'b0;
  end

  assign dec.legal = in_group && size_ok;
  assign dec.size  = insn[23:22];
  assign dec.full  = insn[30];
  assign dec.dst   = insn[4:0];

  // Source indices are resolved by the caller's register file
  assign unused_src_fields = ^{insn[20:16], insn[9:5]};
endmodule

// File: rtl/simd_mac_lane.sv
module simd_mac_lane
  import simd_mac_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] acc,
  input  mac_op_e      op,
  output logic [W-1:0] y
);
  logic [W-1:0] prod;
  logic [W-1:0] cl_prod;

  assign prod = a * b;

  generate
    if (W == 8) begin : g_clmul
      always_comb begin
        cl_prod = '0;
        for (int i = 0; i < W; i++) begin
          if (b[i]) cl_prod = cl_prod ^ (a << i);
        end
      end
    end else begin : g_no_clmul
      assign cl_prod = '0;
    end
  endgenerate

  always_comb begin
    unique case (op)
      OP_MUL:  y = prod;
      OP_PMUL: y = cl_prod;
      OP_MLA:  y = acc + prod;
      OP_MLS:  y = acc - prod;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/simd_mac_datapath.sv
module simd_mac_datapath
  import simd_mac_pkg::*;
#(
  parameter int VW = 128,
  parameter int NUM_SIZES = 3
) (
  input  logic [VW-1:0] vn,
  input  logic [VW-1:0] vm,
  input  logic [VW-1:0] vd,
  input  mac_op_e       op,
  input  logic [1:0]    size,
  output logic [VW-1:0] y
);
  logic [NUM_SIZES-1:0][VW-1:0] by_size;

  generate
    for (genvar gs = 0; gs < NUM_SIZES; gs++) begin : g_size
      localparam int LW = 8 << gs;
      localparam int NL = VW / LW;
      for (genvar gl = 0; gl < NL; gl++) begin : g_lane
        simd_mac_lane #(.W(LW)) u_lane (
          .a  (vn[gl*LW +: LW]),
          .b  (vm[gl*LW +: LW]),
          .acc(vd[gl*LW +: LW]),
          .op (op),
          .y  (by_size[gs][gl*LW +: LW])
        );
      end
    end
  endgenerate

  always_comb begin
    y = '0;
    for (int s = 0; s < NUM_SIZES; s++) begin
      if (size == 2'(s)) y = by_size[s];
    end
  end
endmodule

// File: rtl/simd_mac_unit.sv
module simd_mac_unit
  import simd_mac_pkg::*;
#(
  parameter int VW = 128
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [INSN_W-1:0]    in_insn,
  input  logic [VW-1:0]        in_vn,
  input  logic [VW-1:0]        in_vm,
  input  logic [VW-1:0]        in_vd,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [VW-1:0]        out_result,
  output logic                 out_wr_en,
  output logic                 out_illegal,
  output logic [REG_IDX_W-1:0] out_dst
);
  localparam int HALF = VW / 2;

  mac_dec_t      dec;
  logic [VW-1:0] dp_y;
  logic [VW-1:0] res_next;
  logic          accept;

  simd_mac_decode u_dec (
    .insn(in_insn),
    .dec (dec)
  );

  simd_mac_datapath #(.VW(VW)) u_dp (
    .vn  (in_vn),
    .vm  (in_vm),
    .vd  (in_vd),
    .op  (dec.op),
    .size(dec.size),
    .y   (dp_y)
  );

  always_comb begin
    if (!dec.legal)    res_next = '0;
    else if (dec.full) res_next = dp_y;
    else               res_next = {{HALF{1'b0}}, dp_y[HALF-1:0]};
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_wr_en   <= 1'b0;
      out_illegal <= 1'b0;
      out_dst     <= '0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_result  <= res_next;
      out_wr_en   <= dec.legal;
      out_illegal <= !dec.legal;
      out_dst     <= dec.dst;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  p_reset_r11: assert property (@(posedge clk) rst |=> !out_valid);

  p_accept_r10: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)
                                   && $stable(out_illegal) && $stable(out_dst)));

  p_illegal_clean_r1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> (!out_wr_en && out_result == '0));

  p_pmul_size_r6: assert property (@(posedge clk) disable iff (rst)
    (accept && dec.op == OP_PMUL && dec.size != 2'b00) |=> out_illegal);

  p_size3_r7: assert property (@(posedge clk) disable iff (rst)
    (accept && in_insn[23:22] == 2'b11) |=> out_illegal);

  p_half_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (accept && !in_insn[30]) |=> (out_result[VW-1:HALF] == '0));
endmodule

// File: tb/simd_mac_unit_bench.sv
module simd_mac_unit_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  in_insn = '0;
  logic [127:0] in_vn = '0, in_vm = '0, in_vd = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_result;
  logic         out_wr_en, out_illegal;
  logic [4:0]   out_dst;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  simd_mac_unit u_simd_mac_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .in_vn(in_vn), .in_vm(in_vm), .in_vd(in_vd),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_wr_en(out_wr_en), .out_illegal(out_illegal), .out_dst(out_dst)
  );

  function automatic logic [31:0] enc(bit q, bit u, logic [1:0] sz, bit acc, logic [4:0] d);
    return {1'b0, q, u, 5'b01110, sz, 1'b1, 5'd3, (acc ? 6'b100101 : 6'b100111), 5'd7, d};
  endfunction

  typedef struct packed {
    logic [31:0] insn;
    logic        sel;
    logic        ill;
  } row_t;

  localparam int NR = 18;
  localparam row_t TBL [NR] = '{
    '{enc(1, 0, 2'd0, 0, 5'd1), 1'b0, 1'b0},  // MUL 8
    '{enc(1, 0, 2'd1, 0, 5'd2), 1'b0, 1'b0},  // MUL 16
    '{enc(1, 0, 2'd2, 0, 5'd3), 1'b1, 1'b0},  // MUL 32 all ones
    '{enc(0, 0, 2'd1, 0, 5'd4), 1'b0, 1'b0},  // MUL 16 half
    '{enc(1, 0, 2'd0, 1, 5'd5), 1'b0, 1'b0},  // MLA 8
    '{enc(1, 0, 2'd2, 1, 5'd6), 1'b1, 1'b0},  // MLA 32 all ones
    '{enc(1, 1, 2'd1, 1, 5'd7), 1'b1, 1'b0},  // MLS 16 wrap
    '{enc(0, 1, 2'd0, 1, 5'd8), 1'b0, 1'b0},  // MLS 8 half
    '{enc(1, 1, 2'd0, 0, 5'd9), 1'b0, 1'b0},  // PMUL 8
    '{enc(0, 1, 2'd0, 0, 5'd10), 1'b1, 1'b0}, // PMUL 8 half
    '{enc(1, 1, 2'd1, 0, 5'd11), 1'b0, 1'b1}, // PMUL 16 illegal
    '{enc(1, 1, 2'd2, 0, 5'd12), 1'b0, 1'b1}, // PMUL 32 illegal
    '{enc(1, 0, 2'd3, 0, 5'd13), 1'b0, 1'b1}, // MUL 64 illegal
    '{enc(1, 1, 2'd3, 1, 5'd14), 1'b0, 1'b1}, // MLS 64 illegal
    '{enc(1, 0, 2'd0, 0, 5'd15) | 32'h8000_0000, 1'b0, 1'b1},
    '{(enc(1, 0, 2'd1, 0, 5'd16) & ~32'h0000_FC00) | 32'h0000_8400, 1'b0, 1'b1},
    '{enc(1, 0, 2'd1, 0, 5'd17) & ~32'h0020_0000, 1'b0, 1'b1},
    '{enc(1, 0, 2'd1, 0, 5'd18) | 32'h0100_0000, 1'b0, 1'b1}
  };

  localparam logic [127:0] SA = 128'h80FF_7F01_FFFF_8000_1234_5678_DEAD_BEEF;
  localparam logic [127:0] SB = 128'h02FF_0303_0002_FFFF_9ABC_DEF0_0102_0408;
  localparam logic [127:0] SD = 128'h1111_2222_3333_4444_FFFF_0000_8000_7FFF;

  // Reference from the requirements
  function automatic void ref_model(input logic [31:0] w, input logic [127:0] n, m, d,
                                    output logic [127:0] r, output bit ill);
    bit grp, poly;
    int sz, wd;
    logic [63:0] mk, a, b, c, p;
    grp  = !w[31] && w[28:24] == 5'b01110 && w[21] && w[15] && !w[14]
           && !w[13] && w[12] && w[10];
    sz   = int'(w[23:22]);
    poly = w[29] && w[11];
    ill  = !grp || sz == 3 || (poly && sz != 0);
    r = '0;
    if (ill) return;
    wd = 8 << sz;
    mk = (64'd1 << wd) - 64'd1;
    for (int l = 0; l < 128 / wd; l++) begin
      a = 64'(n >> (l * wd)) & mk;
      b = 64'(m >> (l * wd)) & mk;
      c = 64'(d >> (l * wd)) & mk;
      p = '0;
      if (poly) begin
        for (int j = 0; j < wd; j++) if (b[j]) p = p ^ (a << j);
      end else begin
        p = a * b;
      end
      p = p & mk;
      if (!w[11]) p = (w[29] ? (c - p) : (c + p)) & mk;
      r = r | (128'(p) << (l * wd));
    end
    if (!w[30]) r[127:64] = '0;
  endfunction

  function automatic string req_of(logic [31:0] w, bit ill);
    if (ill) begin
      if (w[23:22] == 2'd3) return "R7";
      if (w[29] && w[11] && !w[31] && w[21] && w[28:24] == 5'b01110
          && w[15:12] == 4'b1001 && w[10]) return "R6";
      return "R1";
    end
    if (!w[30]) return "R8";
    if (w[11]) return w[29] ? "R5" : "R2";
    return w[29] ? "R4" : "R3";
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w, input logic [127:0] n, m, d);
    @(negedge clk);
    in_valid = 1'b1; in_insn = w; in_vn = n; in_vm = m; in_vd = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog act=%h exp=%h", 128'd0, 128'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [127:0] er, held;
    bit eill;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk(out_valid == 1'b0, "R11", 128'(out_valid), 128'd0);
    chk(in_ready == 1'b1, "R11", 128'(in_ready), 128'd1);

    for (int i = 0; i < NR; i++) begin
      logic [127:0] n, m, d;
      n = TBL[i].sel ? '1 : SA;
      m = TBL[i].sel ? '1 : SB;
      d = TBL[i].sel ? '0 : SD;
      ref_model(TBL[i].insn, n, m, d, er, eill);
      send(TBL[i].insn, n, m, d);
      chk(eill == TBL[i].ill, "table", 128'(eill), 128'(TBL[i].ill));
      chk(out_valid && out_result == er, req_of(TBL[i].insn, eill), out_result, er);
      chk(out_illegal == eill && out_wr_en == !eill, req_of(TBL[i].insn, eill),
          128'({out_illegal, out_wr_en}), 128'({eill, !eill}));
      // R9: destination index passes through
      chk(out_dst == TBL[i].insn[4:0], "R9", 128'(out_dst), 128'(TBL[i].insn[4:0]));
    end

    // R5 vs R2: carry-less differs from integer product on 0x03*0x03
    send(enc(1, 1, 2'd0, 0, 5'd0), {16{8'h03}}, {16{8'h03}}, '0);
    chk(out_result == {16{8'h05}}, "R5", out_result, {16{8'h05}});
    send(enc(1, 0, 2'd0, 0, 5'd0), {16{8'h03}}, {16{8'h03}}, '0);
    chk(out_result == {16{8'h09}}, "R2", out_result, {16{8'h09}});

    // R10: back-pressure holds the beat and blocks the next one
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_insn = enc(1, 0, 2'd1, 0, 5'd21);
    in_vn = {8{16'd3}}; in_vm = {8{16'd5}}; in_vd = '0;
    @(negedge clk);
    held = {8{16'd15}};
    chk(out_valid && out_result == held, "R10", out_result, held);
    chk(in_ready == 1'b0, "R10", 128'(in_ready), 128'd0);
    in_insn = enc(1, 0, 2'd1, 0, 5'd22); in_vn = {8{16'd7}};
    repeat (2) @(negedge clk);
    chk(out_valid && out_result == held && out_dst == 5'd21, "R10", out_result, held);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_result == {8{16'd35}} && out_dst == 5'd22, "R10",
        out_result, {8{16'd35}});
    @(negedge clk);
    chk(out_valid == 1'b0, "R10", 128'(out_valid), 128'd0);

    // R11: reset mid-stream clears a pending beat
    out_ready = 1'b0;
    send(enc(1, 0, 2'd0, 0, 5'd1), SA, SB, SD);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    out_ready = 1'b1;
    chk(out_valid == 1'b0, "R11", 128'(out_valid), 128'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule